// File: doc/BRIEF.md
# Debug Register Access Engine

This block sits between the word layer of a debug link and a CPU's general register file. It takes 16-bit host words, decodes register read and register write commands, checks that the core is halted, and reaches one of 16 registers (eight data, eight address) through a read port and a write port. Every host word it accepts is answered with exactly one 16-bit response word plus a status flag. The flag is clear for normal results and set for replies that mean "not ready", "bus error" or "illegal command".

A read takes three host words. The command word is answered "not ready" while the register is fetched. The next two words are answered with the upper half and then the lower half of the register, and their contents are ignored. A write also takes three words: the command, the upper operand half and the lower operand half. The first two are answered "not ready". The last is answered with a completion word, and the whole 32-bit register is written on the following cycle.

Both word streams use valid/ready. A host word is accepted only when no response is waiting, so the response stream applies back-pressure to the command stream. A held response stays fixed until it is taken.

Top module: `dbg_reg_engine`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), rsp_valid and rf_we are 0 and cmd_ready is 1. Any partly received write operand is discarded, so the next host word is decoded as a command.
- R2: A command word has 0x2 in bits 15:12, 0x8 in bits 7:4, and 0x1 (read) or 0x0 (write) in bits 11:8. Bit 3 picks the bank (1 = address, 0 = data) and bits 2:0 pick the register. The register file index is bits 3:0 of the word.
- R3: A read command with the core halted pulses rf_re together with its acceptance and is answered status 1 / data 0x0000. The next two accepted words, whatever they hold, are answered status 0 with register bits 31:16 and then bits 15:0.
- R4: A write command with the core halted is answered status 1 / 0x0000. The upper operand word is answered status 1 / 0x0000. The lower operand word is answered status 0 / 0xFFFF, and rf_we pulses for one cycle with the target index and {upper, lower}.
- R5: A read or write command accepted while core_halted is 0 is answered status 1 / 0x0001. It causes no register file access, takes no operand, and the next word is a command.
- R6: Any word in the command slot that does not match R2 is answered status 1 / 0xFFFF. It causes no register file access, and the engine stays ready for a command.
- R7: Each accepted word (cmd_valid and cmd_ready at an edge) yields exactly one response, valid in the following cycle, in order. cmd_ready is 0 while a response is held.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_status and rsp_data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_halted | input | 1 | Core is halted; sampled when a command word is accepted |
| cmd_valid | input | 1 | Host word offered |
| cmd_ready | output | 1 | Engine can accept a host word |
| cmd_data | input | 16 | Host command or operand word |
| rsp_valid | output | 1 | Response word held |
| rsp_ready | input | 1 | Receiver takes the response |
| rsp_status | output | 1 | 0 normal, 1 not-ready / bus error / illegal |
| rsp_data | output | 16 | Response word |
| rf_re | output | 1 | Register file read strobe |
| rf_raddr | output | 4 | Read index {bank, register} |
| rf_rdata | input | 32 | Read data, valid the cycle after rf_re |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Write index {bank, register} |
| rf_wdata | output | 32 | Write data |

## Verification
The bench builds the engine with its defaults: 16-bit link words and a 3-bit register index, which gives the full 16-entry file. Registers 0 and 7 of both banks are reachable, so the bank bit can be checked apart from the index bits. The link width also fixes the split of each register into an upper and a lower response word, so both halves are compared against a model of the file kept inside the bench.

// File: rtl/dbg_eng_pkg.sv
package dbg_eng_pkg;

  localparam logic [3:0] GRP_REG  = 4'h2;
  localparam logic [3:0] SUB_RD   = 4'h1;
  localparam logic [3:0] SUB_WR   = 4'h0;
  localparam logic [3:0] MARK_REG = 4'h8;

  localparam logic [15:0] RSP_NOTRDY = 16'h0000;
  localparam logic [15:0] RSP_BERR   = 16'h0001;
  localparam logic [15:0] RSP_ILL    = 16'hFFFF;
  localparam logic [15:0] RSP_DONE   = 16'hFFFF;

  typedef enum logic [1:0] {
    CMD_RD,
    CMD_WR,
    CMD_ILL
  } cmd_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_MS,
    ST_RD_LS,
    ST_WR_HI,
    ST_WR_LO
  } eng_state_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_eng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic [WORD_W-1:0] word,
  output cmd_kind_t         kind,
  output logic [ADDR_W-1:0] reg_sel
);

  logic [3:0] grp, sub, mark;

  assign grp     = word[WORD_W-1 -: 4];
  assign sub     = word[WORD_W-5 -: 4];
  assign mark    = word[IDX_W+4 -: 4];
  assign reg_sel = word[ADDR_W-1:0];

  always_comb begin
    kind = CMD_ILL;
    if (grp == GRP_REG && mark == MARK_REG) begin
      if (sub == SUB_RD)      kind = CMD_RD;
      else if (sub == SUB_WR) kind = CMD_WR;
    end
  end

endmodule

// File: rtl/dbg_rsp_slot.sv
module dbg_rsp_slot #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_status,
  input  logic [WORD_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic              rsp_status,
  output logic [WORD_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 1'b0;
      rsp_data   <= '0;
    end else if (load) begin
      rsp_valid  <= 1'b1;
      rsp_status <= load_status;
      rsp_data   <= load_data;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_eng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = IDX_W + 1,
  parameter int REG_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  input  cmd_kind_t         kind,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic              core_halted,
  input  logic [REG_W-1:0]  rf_rdata,
  output logic              load_status,
  output logic [WORD_W-1:0] load_data,
  output logic              rf_re,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [REG_W-1:0]  rf_wdata
);

  eng_state_t        state, nxt;
  logic [ADDR_W-1:0] tgt;
  logic [WORD_W-1:0] hi_buf;
  logic [REG_W-1:0]  rd_buf;
  logic [REG_W-1:0]  wdata_q;
  logic              cap_q, we_q;

  always_comb begin
    nxt         = state;
    load_status = 1'b1;
    load_data   = RSP_NOTRDY;
    rf_re       = 1'b0;
    if (accept) begin
      unique case (state)
        ST_IDLE: begin
          unique case (kind)
            CMD_RD: begin
              if (core_halted) begin
                rf_re = 1'b1;
                nxt   = ST_RD_MS;
              end else begin
                load_data = RSP_BERR;
              end
            end
            CMD_WR: begin
              if (core_halted) nxt = ST_WR_HI;
              else             load_data = RSP_BERR;
            end
            default: load_data = RSP_ILL;
          endcase
        end
        ST_RD_MS: begin
          load_status = 1'b0;
          load_data   = rd_buf[REG_W-1:WORD_W];
          nxt         = ST_RD_LS;
        end
        ST_RD_LS: begin
          load_status = 1'b0;
          load_data   = rd_buf[WORD_W-1:0];
          nxt         = ST_IDLE;
        end
        ST_WR_HI: nxt = ST_WR_LO;
        ST_WR_LO: begin
          load_status = 1'b0;
          load_data   = RSP_DONE;
          nxt         = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cap_q   <= 1'b0;
      we_q    <= 1'b0;
      tgt     <= '0;
      hi_buf  <= '0;
      rd_buf  <= '0;
      wdata_q <= '0;
    end else begin
      state <= nxt;
      cap_q <= rf_re;
      we_q  <= accept && state == ST_WR_LO;
      if (cap_q) rd_buf <= rf_rdata;
      if (accept && state == ST_IDLE && kind != CMD_ILL) tgt <= reg_sel;
      if (accept && state == ST_WR_HI) hi_buf <= word;
      if (accept && state == ST_WR_LO) wdata_q <= {hi_buf, word};
    end
  end

  assign rf_we    = we_q;
  assign rf_waddr = tgt;
  assign rf_wdata = wdata_q;

endmodule

// File: rtl/dbg_reg_engine.sv
module dbg_reg_engine
  import dbg_eng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 3,
  localparam int ADDR_W = IDX_W + 1,
  localparam int REG_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_halted,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_status,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rf_re,
  output logic [ADDR_W-1:0] rf_raddr,
  input  logic [REG_W-1:0]  rf_rdata,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [REG_W-1:0]  rf_wdata
);

  cmd_kind_t         kind;
  logic [ADDR_W-1:0] reg_sel;
  logic              accept;
  logic              ld_status;
  logic [WORD_W-1:0] ld_data;

  assign cmd_ready = !rsp_valid;
  assign accept    = cmd_valid && cmd_ready;
  assign rf_raddr  = reg_sel;

  dbg_cmd_decode #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .word    (cmd_data),
    .kind    (kind),
    .reg_sel (reg_sel)
  );

  dbg_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .word        (cmd_data),
    .kind        (kind),
    .reg_sel     (reg_sel),
    .core_halted (core_halted),
    .rf_rdata    (rf_rdata),
    .load_status (ld_status),
    .load_data   (ld_data),
    .rf_re       (rf_re),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .rf_wdata    (rf_wdata)
  );

  dbg_rsp_slot #(.WORD_W(WORD_W)) u_rsp (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .load_status (ld_status),
    .load_data   (ld_data),
    .rsp_ready   (rsp_ready),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_data    (rsp_data)
  );

endmodule

// File: rtl/dbg_reg_engine_chk.sv
module dbg_reg_engine_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              core_halted,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_status,
  input logic [WORD_W-1:0] rsp_data,
  input logic              rf_re,
  input logic              rf_we
);

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rf_we));

  p_read_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    rf_re |-> (cmd_valid && cmd_ready && core_halted));

  p_write_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  p_write_ack_r4: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rsp_valid && !rsp_status && rsp_data == {WORD_W{1'b1}}));

  p_one_rsp_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> rsp_valid);

  p_ready_gate_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_data)));

endmodule

bind dbg_reg_engine dbg_reg_engine_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .core_halted (core_halted),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_status  (rsp_status),
  .rsp_data    (rsp_data),
  .rf_re       (rf_re),
  .rf_we       (rf_we)
);

// File: tb/dbg_reg_engine_bench.sv
`timescale 1ns/1ps
module dbg_reg_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_halted = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_status;
  logic [15:0] rsp_data;
  logic        rf_re;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata = '0;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_reg_engine u_dbg_reg_engine (
    .clk(clk), .rst(rst), .core_halted(core_halted),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // register file model and port monitors
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  int          re_cnt = 0;
  int          we_cnt = 0;
  logic [3:0]  last_waddr = '0;
  logic [31:0] last_wdata = '0;

  function automatic logic [31:0] seed_val(int i);
    return 32'h1357_9BDF ^ (32'(i) * 32'h0110_0223);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]     = seed_val(i);
      exp_mem[i] = seed_val(i);
    end
  end

  always @(posedge clk) begin
    if (rf_re) begin
      rf_rdata <= mem[rf_raddr];
      re_cnt   <= re_cnt + 1;
    end
    if (rf_we) begin
      mem[rf_waddr] <= rf_wdata;
      we_cnt        <= we_cnt + 1;
      last_waddr    <= rf_waddr;
      last_wdata    <= rf_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one host word, returns {status, data} of its response
  task automatic xfer(input string req, input logic [15:0] w, output logic [16:0] r);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req, "response valid after word", {31'd0, rsp_valid}, 32'd1);
    r = {rsp_status, rsp_data};
  endtask

  function automatic logic [15:0] rd_cmd(bit ad, int idx);
    return {4'h2, 4'h1, 4'h8, ad, 3'(idx)};
  endfunction

  function automatic logic [15:0] wr_cmd(bit ad, int idx);
    return {4'h2, 4'h0, 4'h8, ad, 3'(idx)};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "cmd_ready after reset", {31'd0, cmd_ready}, 32'd1);
    chk("R1", "rf_we after reset", {31'd0, rf_we}, 32'd0);
  endtask

  // R2 R3: read through the three-word sequence
  task automatic t_read(input bit ad, input int idx, input logic [15:0] filler);
    logic [16:0] r;
    int re0;
    logic [31:0] e;
    e = exp_mem[{ad, 3'(idx)}];
    re0 = re_cnt;
    xfer("R3", rd_cmd(ad, idx), r);
    chk("R3", "read cmd slot not-ready", {15'd0, r}, {15'd0, 1'b1, 16'h0000});
    chk("R3", "one read strobe", 32'(re_cnt - re0), 32'd1);
    xfer("R3", filler, r);
    chk("R2", "upper half of selected register", {15'd0, r}, {15'd0, 1'b0, e[31:16]});
    xfer("R3", filler, r);
    chk("R2", "lower half of selected register", {15'd0, r}, {15'd0, 1'b0, e[15:0]});
  endtask

  task automatic t_write(input bit ad, input int idx, input logic [31:0] val);
    logic [16:0] r;
    int we0;
    we0 = we_cnt;
    xfer("R4", wr_cmd(ad, idx), r);
    chk("R4", "write cmd slot not-ready", {15'd0, r}, {15'd0, 1'b1, 16'h0000});
    xfer("R4", val[31:16], r);
    chk("R4", "upper operand not-ready", {15'd0, r}, {15'd0, 1'b1, 16'h0000});
    xfer("R4", val[15:0], r);
    chk("R4", "lower operand completion", {15'd0, r}, {15'd0, 1'b0, 16'hFFFF});
    @(negedge clk);
    chk("R4", "single write strobe", 32'(we_cnt - we0), 32'd1);
    chk("R4", "write index", {28'd0, last_waddr}, {28'd0, ad, 3'(idx)});
    chk("R4", "write data", last_wdata, val);
    exp_mem[{ad, 3'(idx)}] = val;
  endtask

  task automatic t_not_halted;
    logic [16:0] r;
    int re0, we0;
    re0 = re_cnt; we0 = we_cnt;
    core_halted = 1'b0;
    xfer("R5", rd_cmd(1'b0, 2), r);
    chk("R5", "read while running -> bus error", {15'd0, r}, {15'd0, 1'b1, 16'h0001});
    xfer("R5", wr_cmd(1'b1, 2), r);
    chk("R5", "write while running -> bus error", {15'd0, r}, {15'd0, 1'b1, 16'h0001});
    xfer("R5", 16'h1234, r);
    chk("R5", "next word is a command slot", {15'd0, r}, {15'd0, 1'b1, 16'hFFFF});
    @(negedge clk);
    chk("R5", "no read strobe", 32'(re_cnt - re0), 32'd0);
    chk("R5", "no write strobe", 32'(we_cnt - we0), 32'd0);
    core_halted = 1'b1;
    t_read(1'b1, 2, 16'h0000);
  endtask

  task automatic t_illegal;
    logic [16:0] r;
    int re0, we0;
    logic [15:0] words [5] = '{16'h0000, 16'h2190, 16'h3180, 16'h2280, 16'h2170};
    re0 = re_cnt; we0 = we_cnt;
    foreach (words[i]) begin
      xfer("R6", words[i], r);
      chk("R6", $sformatf("illegal word %h", words[i]), {15'd0, r}, {15'd0, 1'b1, 16'hFFFF});
    end
    @(negedge clk);
    chk("R6", "no read strobe", 32'(re_cnt - re0), 32'd0);
    chk("R6", "no write strobe", 32'(we_cnt - we0), 32'd0);
  endtask

  task automatic t_backpressure;
    logic [16:0] r;
    logic [31:0] e;
    e = exp_mem[4'd9];
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1;
    cmd_data  = 16'h3180;
    @(negedge clk);
    cmd_data = rd_cmd(1'b1, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R8", "held response valid", {31'd0, rsp_valid}, 32'd1);
      chk("R8", "held response value", {15'd0, rsp_status, rsp_data}, {15'd0, 1'b1, 16'hFFFF});
      chk("R7", "cmd_ready low while held", {31'd0, cmd_ready}, 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7", "queued read accepted after release", {15'd0, rsp_status, rsp_data}, {15'd0, 1'b1, 16'h0000});
    xfer("R3", 16'hFFFF, r);
    chk("R3", "upper half after stall", {15'd0, r}, {15'd0, 1'b0, e[31:16]});
    xfer("R3", 16'hFFFF, r);
    chk("R3", "lower half after stall", {15'd0, r}, {15'd0, 1'b0, e[15:0]});
  endtask

  task automatic t_reset_mid_write;
    logic [16:0] r;
    int we0;
    we0 = we_cnt;
    xfer("R1", wr_cmd(1'b0, 6), r);
    xfer("R1", 16'hDEAD, r);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "rsp_valid after mid-write reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "cmd_ready after mid-write reset", {31'd0, cmd_ready}, 32'd1);
    t_read(1'b0, 6, 16'h2080);
    chk("R1", "partial operand never written", 32'(we_cnt - we0), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read(1'b0, 0, 16'h2181);
    t_read(1'b1, 7, 16'h0000);
    t_write(1'b0, 5, 32'hCAFE_0005);
    t_write(1'b1, 5, 32'h0BAD_F00D);
    t_write(1'b1, 0, 32'hFFFF_0000);
    t_write(1'b0, 7, 32'h0000_FFFF);
    t_read(1'b0, 5, 16'h0000);
    t_read(1'b1, 5, 16'h0000);
    t_read(1'b1, 0, 16'h0000);
    t_read(1'b0, 7, 16'h0000);
    t_not_halted();
    t_illegal();
    t_backpressure();
    t_reset_mid_write();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule